// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block walks a PCIe root-port controller from power-on to the point where configuration requests may be issued. After a start pulse it selects root-complex mode and releases the two controller resets, powerdown first and then soft reset. It then waits a settle time and requests PHY initialisation while link training is held off. Next it pulses the active-low fundamental reset (PERST#) and enables link training. It waits for link-up, observes a quiet period and finally raises a config-ready flag.

All delays are counted in clock cycles, derived from a clock-frequency parameter given in kHz. A parameter states whether a PERST# line exists. Without one, the PERST# pulse and the quiet period are skipped. A link-up timeout ends in a fail state. A synchronous abort input returns the sequencer to its power-on state at any time.

Top module: `rp_bringup_seq`

## Requirements
- R1: `rc_mode_o` is 0 in the idle state. It goes to 1 in the cycle after start is sampled, which is one cycle before any reset is released, and it stays 1 until abort or reset.
- R2: `pd_rst_o` (1 = powerdown reset held) drops one cycle after `rc_mode_o` rises. `soft_rst_o` (1 = soft reset held) drops exactly one cycle later. Soft reset is never released while powerdown reset is held.
- R3: `phy_init_req_o` rises exactly CLK_KHZ cycles (1 ms) after `soft_rst_o` falls.
- R4: `phy_init_req_o` stays high until `phy_init_done_i` is sampled high, and `ltssm_en_o` is 0 throughout that time.
- R5: With HAS_PERST=1, `perst_n_o` goes low in the cycle after PHY init completes. It stays low for ceil(CLK_KHZ/10) cycles (100 µs). At every other time, including from reset, it is 1.
- R6: `ltssm_en_o` rises in the same cycle that `perst_n_o` returns high. It then stays high while the block waits for `link_up_i`.
- R7: With HAS_PERST=1, `cfg_ready_o` rises CLK_KHZ*100 cycles (100 ms) after the cycle in which `link_up_i` is sampled high.
- R8: With HAS_PERST=0, `perst_n_o` is always 1. `ltssm_en_o` rises in the cycle after PHY init completes, and `cfg_ready_o` rises in the cycle after `link_up_i` is sampled high.
- R9: If `link_up_i` is not seen within CLK_KHZ*LINK_TIMEOUT_MS cycles of enabling link training, `fail_o` goes to 1, `ltssm_en_o` returns to 0 and `cfg_ready_o` stays 0.
- R10: `abort_i` sampled high returns the block to idle on the next cycle. Idle means both resets held, `rc_mode_o`=0, `ltssm_en_o`=0 and `perst_n_o`=1. Abort wins over a simultaneous start.
- R11: `start_i` has no effect unless the block is idle; a start pulse mid-sequence, in ready or in fail leaves the outputs on their course.
- R12: During and right after reset the outputs show the idle state: `rc_mode_o`=0, `pd_rst_o`=1, `soft_rst_o`=1, `phy_init_req_o`=0, `perst_n_o`=1, `ltssm_en_o`=0, `cfg_ready_o`=0, `fail_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the bring-up sequence (honoured only when idle) |
| abort_i | input | 1 | Synchronous return to idle |
| phy_init_done_i | input | 1 | PHY has finished initialising |
| link_up_i | input | 1 | Link training reached link-up |
| rc_mode_o | output | 1 | Device-type strap: 1 selects root-complex mode |
| pd_rst_o | output | 1 | Powerdown reset, 1 = held |
| soft_rst_o | output | 1 | Controller soft reset, 1 = held |
| phy_init_req_o | output | 1 | Request to initialise the PHY |
| perst_n_o | output | 1 | Active-low fundamental reset to the downstream device |
| ltssm_en_o | output | 1 | Link training enable |
| cfg_ready_o | output | 1 | Configuration requests allowed |
| fail_o | output | 1 | Link-up timeout occurred |

## Verification
Every output is decoded from the state register. An input sampled at a rising edge therefore shows at the outputs right after that edge. The strap comes one edge after start, and each reset release follows one edge later. Each timed step lasts exactly its cycle count from the first cycle its outputs are visible. The bench holds a behavioural model that updates on the same rising edge from the same sampled inputs, and it compares every output of two instances (with and without PERST#) at each falling edge. Directed checks measure the settle gap in falling-edge steps and check the abort and start-ignore cases one cycle after the pulse.

// File: rtl/rp_seq_pkg.sv
package rp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STRAP,
        ST_PD_REL,
        ST_SETTLE,
        ST_PHY_INIT,
        ST_PERST,
        ST_LINK_WAIT,
        ST_QUIET,
        ST_READY,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic rc_mode;
        logic pd_rst;
        logic soft_rst;
        logic phy_req;
        logic perst_n;
        logic ltssm_en;
        logic cfg_ready;
        logic fail;
    } ctrl_t;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

endpackage

// File: rtl/rp_seq_timer.sv
module rp_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != {W{1'b1}}) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // limit is never zero; the step lasts exactly limit cycles
    assign expired = (cnt_q == limit - W'(1));
endmodule

// File: rtl/rp_seq_decode.sv
module rp_seq_decode
    import rp_seq_pkg::*;
#(
    parameter bit HAS_PERST = 1'b1
) (
    input  seq_state_e st,
    output ctrl_t      ctrl
);
    logic perst_n_raw;

    always_comb begin
        ctrl.rc_mode   = (st != ST_IDLE);
        ctrl.pd_rst    = (st == ST_IDLE) || (st == ST_STRAP);
        ctrl.soft_rst  = (st == ST_IDLE) || (st == ST_STRAP) || (st == ST_PD_REL);
        ctrl.phy_req   = (st == ST_PHY_INIT);
        ctrl.ltssm_en  = (st == ST_LINK_WAIT) || (st == ST_QUIET) || (st == ST_READY);
        ctrl.cfg_ready = (st == ST_READY);
        ctrl.fail      = (st == ST_FAIL);
        ctrl.perst_n   = perst_n_raw;
    end

    generate
        if (HAS_PERST) begin : g_perst
            assign perst_n_raw = (st != ST_PERST);
        end else begin : g_no_perst
            assign perst_n_raw = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
    import rp_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ         = 200000,
    parameter int unsigned LINK_TIMEOUT_MS = 50,
    parameter bit          HAS_PERST       = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic phy_init_done_i,
    input  logic link_up_i,
    output logic rc_mode_o,
    output logic pd_rst_o,
    output logic soft_rst_o,
    output logic phy_init_req_o,
    output logic perst_n_o,
    output logic ltssm_en_o,
    output logic cfg_ready_o,
    output logic fail_o
);
    localparam int unsigned CYC_1MS     = CLK_KHZ;
    localparam int unsigned CYC_100US   = (CLK_KHZ + 9) / 10;
    localparam int unsigned CYC_100MS   = CLK_KHZ * 100;
    localparam int unsigned CYC_LINK_TO = CLK_KHZ * LINK_TIMEOUT_MS;
    localparam int unsigned MAX_LIM     = (CYC_100MS > CYC_LINK_TO) ? CYC_100MS : CYC_LINK_TO;
    localparam int          CW          = $clog2(MAX_LIM + 1);

    seq_regs_t     cur_q, nxt_d;
    logic [CW-1:0] lim;
    logic          tmr_done;
    logic          tmr_clr;
    ctrl_t         ctrl;

    always_comb begin
        nxt_d = cur_q;
        lim   = CW'(1);
        unique case (cur_q.st)
            ST_IDLE:     if (start_i) nxt_d.st = ST_STRAP;
            ST_STRAP:    nxt_d.st = ST_PD_REL;
            ST_PD_REL:   nxt_d.st = ST_SETTLE;
            ST_SETTLE: begin
                lim = CW'(CYC_1MS);
                if (tmr_done) nxt_d.st = ST_PHY_INIT;
            end
            ST_PHY_INIT: begin
                if (phy_init_done_i) nxt_d.st = HAS_PERST ? ST_PERST : ST_LINK_WAIT;
            end
            ST_PERST: begin
                lim = CW'(CYC_100US);
                if (tmr_done) nxt_d.st = ST_LINK_WAIT;
            end
            ST_LINK_WAIT: begin
                lim = CW'(CYC_LINK_TO);
                if (link_up_i)     nxt_d.st = HAS_PERST ? ST_QUIET : ST_READY;
                else if (tmr_done) nxt_d.st = ST_FAIL;
            end
            ST_QUIET: begin
                lim = CW'(CYC_100MS);
                if (tmr_done) nxt_d.st = ST_READY;
            end
            ST_READY:    nxt_d.st = ST_READY;
            ST_FAIL:     nxt_d.st = ST_FAIL;
            default:     nxt_d.st = ST_IDLE;
        endcase
        if (abort_i) nxt_d.st = ST_IDLE;
    end

    assign tmr_clr = (nxt_d.st != cur_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.st <= ST_IDLE;
        else        cur_q    <= nxt_d;
    end

    rp_seq_timer #(.W(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (lim),
        .expired (tmr_done)
    );

    rp_seq_decode #(.HAS_PERST(HAS_PERST)) u_decode (
        .st   (cur_q.st),
        .ctrl (ctrl)
    );

    assign rc_mode_o      = ctrl.rc_mode;
    assign pd_rst_o       = ctrl.pd_rst;
    assign soft_rst_o     = ctrl.soft_rst;
    assign phy_init_req_o = ctrl.phy_req;
    assign perst_n_o      = ctrl.perst_n;
    assign ltssm_en_o     = ctrl.ltssm_en;
    assign cfg_ready_o    = ctrl.cfg_ready;
    assign fail_o         = ctrl.fail;
endmodule

// File: rtl/rp_seq_checker.sv
module rp_seq_checker #(
    parameter int unsigned CLK_KHZ   = 200000,
    parameter bit          HAS_PERST = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic abort_i,
    input logic rc_mode_o,
    input logic pd_rst_o,
    input logic soft_rst_o,
    input logic phy_init_req_o,
    input logic perst_n_o,
    input logic ltssm_en_o,
    input logic cfg_ready_o,
    input logic fail_o
);
    localparam int unsigned MIN_SETTLE = CLK_KHZ;
    localparam int unsigned MIN_PERST  = (CLK_KHZ + 9) / 10;

    logic [31:0] settle_cnt_q, perst_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_cnt_q <= '0;
            perst_cnt_q  <= '0;
        end else begin
            if (soft_rst_o)                     settle_cnt_q <= '0;
            else if (settle_cnt_q != 32'hFFFFFFFF) settle_cnt_q <= settle_cnt_q + 1;
            if (perst_n_o)                      perst_cnt_q <= '0;
            else if (perst_cnt_q != 32'hFFFFFFFF)  perst_cnt_q <= perst_cnt_q + 1;
        end
    end

    assert_strap_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_rst_o |-> rc_mode_o);

    assert_reset_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_o |-> !pd_rst_o);

    assert_soft_follows_R2: assert property (@(posedge clk) disable iff (!rst_n || abort_i)
        $fell(pd_rst_o) |=> $fell(soft_rst_o));

    assert_settle_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_init_req_o) |-> (settle_cnt_q >= MIN_SETTLE));

    assert_ltssm_off_phy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phy_init_req_o |-> !ltssm_en_o);

    assert_perst_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (perst_cnt_q >= MIN_PERST));

    assert_ltssm_after_perst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> ltssm_en_o);

    assert_ready_training_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready_o |-> (ltssm_en_o && !fail_o));

    generate
        if (!HAS_PERST) begin : g_no_perst
            assert_perst_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                perst_n_o);
        end
    endgenerate

    assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (!ltssm_en_o && !cfg_ready_o));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (pd_rst_o && soft_rst_o && !rc_mode_o && !ltssm_en_o && perst_n_o));
endmodule

bind rp_bringup_seq rp_seq_checker #(.CLK_KHZ(CLK_KHZ), .HAS_PERST(HAS_PERST)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .abort_i        (abort_i),
    .rc_mode_o      (rc_mode_o),
    .pd_rst_o       (pd_rst_o),
    .soft_rst_o     (soft_rst_o),
    .phy_init_req_o (phy_init_req_o),
    .perst_n_o      (perst_n_o),
    .ltssm_en_o     (ltssm_en_o),
    .cfg_ready_o    (cfg_ready_o),
    .fail_o         (fail_o)
);

// File: tb/sim_rp_bringup_seq.sv
`timescale 1ns/1ps
module sim_rp_bringup_seq;
    localparam int KHZ    = 20;
    localparam int TO_MS  = 5;
    localparam int T1MS   = KHZ;
    localparam int T100US = (KHZ + 9) / 10;
    localparam int T100MS = KHZ * 100;
    localparam int TTO    = KHZ * TO_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0, phy_done = 1'b0, link = 1'b0;

    logic [7:0] o0, o1;   // {rc,pd,soft,phy,perst_n,ltssm,ready,fail}

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rp_bringup_seq #(.CLK_KHZ(KHZ), .LINK_TIMEOUT_MS(TO_MS), .HAS_PERST(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .phy_init_done_i(phy_done), .link_up_i(link),
        .rc_mode_o(o0[7]), .pd_rst_o(o0[6]), .soft_rst_o(o0[5]), .phy_init_req_o(o0[4]),
        .perst_n_o(o0[3]), .ltssm_en_o(o0[2]), .cfg_ready_o(o0[1]), .fail_o(o0[0]));

    rp_bringup_seq #(.CLK_KHZ(KHZ), .LINK_TIMEOUT_MS(TO_MS), .HAS_PERST(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .phy_init_done_i(phy_done), .link_up_i(link),
        .rc_mode_o(o1[7]), .pd_rst_o(o1[6]), .soft_rst_o(o1[5]), .phy_init_req_o(o1[4]),
        .perst_n_o(o1[3]), .ltssm_en_o(o1[2]), .cfg_ready_o(o1[1]), .fail_o(o1[0]));

    // behavioural reference: phase 0 idle,1 strap,2 pd off,3 settle,4 phy,
    // 5 perst,6 link wait,7 quiet,8 ready,9 fail
    int ph [2];
    int cnt[2];

    function automatic logic [7:0] expect_out(int p, bit has_perst);
        logic [7:0] e;
        e[7] = (p != 0);
        e[6] = (p <= 1);
        e[5] = (p <= 2);
        e[4] = (p == 4);
        e[3] = !(has_perst && p == 5);
        e[2] = (p == 6 || p == 7 || p == 8);
        e[1] = (p == 8);
        e[0] = (p == 9);
        return e;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < 2; i++) begin
            bit hp;
            int nx;
            hp = (i == 0);
            if (!rst_n) begin
                ph[i] = 0; cnt[i] = 0;
            end else begin
                nx = ph[i];
                case (ph[i])
                    0: if (start) nx = 1;
                    1: nx = 2;
                    2: nx = 3;
                    3: if (cnt[i] == T1MS - 1) nx = 4;
                    4: if (phy_done) nx = hp ? 5 : 6;
                    5: if (cnt[i] == T100US - 1) nx = 6;
                    6: if (link) nx = hp ? 7 : 8; else if (cnt[i] == TTO - 1) nx = 9;
                    7: if (cnt[i] == T100MS - 1) nx = 8;
                    default: nx = ph[i];
                endcase
                if (abort) nx = 0;
                cnt[i] = (nx != ph[i]) ? 0 : cnt[i] + 1;
                ph[i]  = nx;
            end
        end
    end

    task automatic chk(string tag, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    // per-cycle compare, away from the active edge
    always @(negedge clk) begin
        cycles++;
        for (int i = 0; i < 2; i++) begin
            logic [7:0] e, g;
            e = expect_out(ph[i], i == 0);
            g = (i == 0) ? o0 : o1;
            if (!rst_n) begin
                chk("R12", g[7], e[7], "rc_mode in reset");
                chk("R12", g[6], e[6], "pd_rst in reset");
                chk("R12", g[3], e[3], "perst_n in reset");
            end else if (i == 1) begin
                chk("R8", g[7], e[7], "u1 rc_mode");
                chk("R8", g[6], e[6], "u1 pd_rst");
                chk("R8", g[5], e[5], "u1 soft_rst");
                chk("R8", g[4], e[4], "u1 phy_init_req");
                chk("R8", g[3], e[3], "u1 perst_n");
                chk("R8", g[2], e[2], "u1 ltssm_en");
                chk("R8", g[1], e[1], "u1 cfg_ready");
                chk("R9", g[0], e[0], "u1 fail");
            end else begin
                chk("R1", g[7], e[7], "rc_mode");
                chk("R2", g[6], e[6], "pd_rst");
                chk("R2", g[5], e[5], "soft_rst");
                chk("R4", g[4], e[4], "phy_init_req");
                chk("R5", g[3], e[3], "perst_n");
                chk("R6", g[2], e[2], "ltssm_en");
                chk("R7", g[1], e[1], "cfg_ready");
                chk("R9", g[0], e[0], "fail");
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic pulse_abort();
        abort = 1'b1; tick(1); abort = 1'b0;
    endtask

    initial begin
        int gap;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R12", o0[6] & o0[5] & o0[3], 1'b1, "idle resets held after reset");

        // full sequence
        pulse_start();
        while (o0[5]) tick(1);
        gap = 0;
        while (!o0[4] && gap < 1000) begin tick(1); gap++; end
        chk("R3", gap == T1MS, 1'b1, $sformatf("settle gap %0d vs %0d", gap, T1MS));
        tick(3);
        pulse_start();                 // R11: ignored mid-sequence
        chk("R11", o0[4], 1'b1, "still in PHY init after start pulse");
        phy_done = 1'b1; tick(1); phy_done = 1'b0;
        tick(10);
        link = 1'b1;
        tick(T100MS + 20);
        chk("R7", o0[1], 1'b1, "u0 config ready");
        chk("R8", o1[1], 1'b1, "u1 config ready");
        pulse_start();                 // R11: ignored in ready
        tick(2);
        chk("R11", o0[1], 1'b1, "ready kept after start pulse");
        pulse_abort();
        chk("R10", o0[6] & o0[5] & ~o0[7], 1'b1, "abort to idle");
        link = 1'b0;
        tick(3);

        // link timeout
        phy_done = 1'b1;
        pulse_start();
        tick(T1MS + TTO + 30);
        chk("R9", o0[0] & ~o0[2], 1'b1, "u0 fail with ltssm off");
        chk("R9", o1[0] & ~o1[2], 1'b1, "u1 fail with ltssm off");
        pulse_start();                 // R11: ignored in fail
        chk("R11", o0[0], 1'b1, "fail kept after start pulse");

        // abort and start together
        abort = 1'b1; start = 1'b1; tick(1); abort = 1'b0; start = 1'b0;
        chk("R10", o0[7], 1'b0, "abort beats start");
        tick(2);

        // abort mid link wait
        pulse_start();
        tick(T1MS + 8);
        pulse_abort();
        chk("R10", o0[2] | o1[2], 1'b0, "ltssm off after abort");
        phy_done = 1'b0;
        tick(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule